// File: doc/BRIEF.md
# Memory-mapped IO register bank

This block is a word-addressed peripheral slave on the data bus of a single-cycle processor. It claims a 64-byte register page at 0xffff_0000 and turns loads and stores there into board-level effects. Reads return slices of the switch inputs or one half of a free-running 64-bit cycle counter. Stores set four single indicator LEDs, a 16-bit LED bank and two seven-segment value registers, and each of these can also be read back.

A second window holds 600 words starting at 0xffff_0100. The block only recognises it: it raises a select, computes the word index and passes the store strobe and the data on to an external video text buffer. It then returns that buffer's read word. Every other address reads as zero, and a store to it changes nothing. The single read-data word feeds the processor's data multiplexer. The read path is combinational from the address, and stores commit on the rising clock edge.

Top module: `mmio_regbank`

## Requirements
- R1: While reset is high, and after reset releases, all writable registers and the cycle counter are zero. led_out, seg_left and seg_right read 0, and offsets 0x18 and 0x1c read 0 during reset.
- R2: Offset 0x04 reads sw_in[23] in bit 0. Offset 0x08 reads sw_in[22:20] in bits 2:0. Offset 0x0c reads sw_in[15:8] in bits 7:0 and offset 0x10 reads sw_in[7:0] in bits 7:0. All other bits are zero, with no sign extension.
- R3: The 64-bit counter rises by one on every clock edge out of reset. Offset 0x18 reads bits 63:32 and offset 0x1c reads bits 31:0.
- R4: Offsets 0x20, 0x24, 0x28 and 0x2c each store bus_wdata[0] and drive led_out[19], [18], [17] and [16] in that order. Each reads back in bit 0 with the upper bits zero.
- R5: Offset 0x30 stores a full 32-bit word onto seg_left and offset 0x34 stores one onto seg_right. Both read back unchanged.
- R6: Offset 0x38 stores bus_wdata[15:0] onto led_out[15:0] and reads back zero-extended.
- R7: Offsets 0x00, 0x14 and 0x3c read zero. A store to them, or to the read-only offsets 0x04 to 0x1c, changes no output and no readable register.
- R8: Addresses 0xffff_0100 to 0xffff_0a5c raise vga_sel. vga_idx equals (address - 0xffff_0100) >> 2, from 0 to 599. vga_we equals bus_we, vga_wdata equals bus_wdata and bus_rdata equals vga_rdata.
- R9: Addresses outside both windows, including 0xffff_0040, 0xffff_00fc and 0xffff_0a60, leave vga_sel and vga_we low. They read zero, and a store to them changes no register.
- R10: A store takes effect only on a rising edge with bus_we high. During the store cycle bus_rdata still shows the old value, and the new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address from the processor |
| bus_we | input | 1 | Store strobe |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Read data to the processor's data multiplexer |
| sw_in | input | 24 | Board switch inputs |
| led_out | output | 20 | Indicator LEDs [19:16] and LED bank [15:0] |
| seg_left | output | 32 | Left seven-segment display value |
| seg_right | output | 32 | Right seven-segment display value |
| vga_sel | output | 1 | Address falls in the video text-buffer window |
| vga_we | output | 1 | Store strobe forwarded to the text buffer |
| vga_idx | output | 10 | Word index inside the text buffer |
| vga_wdata | output | 32 | Store data forwarded to the text buffer |
| vga_rdata | input | 32 | Read word returned by the text buffer |

## Verification
A store and a readback of the same register can fall in the same cycle, because the address that steers the write also selects the read word. The bench holds the LED-bank address with the store strobe high. It samples bus_rdata before the edge and expects the old bank value, then samples again after the edge and expects the new one. The next cycle has the strobe low and different data on the bus, and bus_rdata must stay unchanged.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] PAGE_BASE = 32'hffff_0000;
    localparam int PAGE_WORDS     = 16;
    localparam int PAGE_IDX_W     = $clog2(PAGE_WORDS);
    localparam int PAGE_SPAN_BITS = PAGE_IDX_W + 2;

    localparam logic [ADDR_W-1:0] VGA_BASE = 32'hffff_0100;
    localparam int VGA_WORDS = 600;
    localparam int VGA_IDX_W = $clog2(VGA_WORDS);
    localparam logic [ADDR_W-1:0] VGA_END = VGA_BASE + ADDR_W'(VGA_WORDS * 4);

    localparam int TIMER_W = 64;
    localparam int IND_N   = 4;
    localparam int BANK_W  = 16;
    localparam int SEG_W   = 32;
    localparam int SW_W    = 24;
    localparam int LED_W   = IND_N + BANK_W;

    localparam int SW_MODE_BIT = 23;
    localparam int SW_CASE_HI  = 22;
    localparam int SW_CASE_LO  = 20;
    localparam int SW_OPA_HI   = 15;
    localparam int SW_OPA_LO   = 8;
    localparam int SW_OPB_HI   = 7;
    localparam int SW_OPB_LO   = 0;
    localparam int SW_CASE_W   = SW_CASE_HI - SW_CASE_LO + 1;
    localparam int SW_OP_W     = SW_OPA_HI - SW_OPA_LO + 1;

    localparam int IND_BASE_IDX = 8;

    typedef enum logic [PAGE_IDX_W-1:0] {
        RG_RSV_LO = 4'd0,
        RG_MODE   = 4'd1,
        RG_CASE   = 4'd2,
        RG_OPA    = 4'd3,
        RG_OPB    = 4'd4,
        RG_RSV_KP = 4'd5,
        RG_TM_HI  = 4'd6,
        RG_TM_LO  = 4'd7,
        RG_IND0   = 4'd8,
        RG_IND1   = 4'd9,
        RG_IND2   = 4'd10,
        RG_IND3   = 4'd11,
        RG_SEG_L  = 4'd12,
        RG_SEG_R  = 4'd13,
        RG_BANK   = 4'd14,
        RG_RSV_HI = 4'd15
    } reg_idx_e;

    typedef struct packed {
        logic                 page_hit;
        reg_idx_e             idx;
        logic                 vga_hit;
        logic [VGA_IDX_W-1:0] vga_idx;
    } bus_dec_t;

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output bus_dec_t          dec
);

    logic [ADDR_W-1:0] vga_off;
    logic              unused_dec;

    always_comb begin
        vga_off      = addr - VGA_BASE;
        dec.page_hit = (addr[ADDR_W-1:PAGE_SPAN_BITS] == PAGE_BASE[ADDR_W-1:PAGE_SPAN_BITS]);
        dec.idx      = reg_idx_e'(addr[PAGE_SPAN_BITS-1:2]);
        dec.vga_hit  = (addr >= VGA_BASE) && (addr < VGA_END);
        dec.vga_idx  = vga_off[VGA_IDX_W+1:2];
    end

    assign unused_dec = ^{addr[1:0], vga_off[1:0], vga_off[ADDR_W-1:VGA_IDX_W+2]};

endmodule

// File: rtl/mmio_timer.sv
module mmio_timer
    import mmio_pkg::*;
#(
    parameter int W = TIMER_W
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + W'(1);
    end

endmodule

// File: rtl/mmio_wregs.sv
module mmio_wregs
    import mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [IND_N-1:0]  ind,
    output logic [SEG_W-1:0]  seg_l,
    output logic [SEG_W-1:0]  seg_r,
    output logic [BANK_W-1:0] bank
);

    for (genvar k = 0; k < IND_N; k++) begin : g_ind
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (wr_en && (idx == reg_idx_e'(PAGE_IDX_W'(IND_BASE_IDX + k))))
                bit_q <= wdata[0];
        end
        assign ind[k] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_l <= '0;
            seg_r <= '0;
            bank  <= '0;
        end else if (wr_en) begin
            case (idx)
                RG_SEG_L: seg_l <= wdata[SEG_W-1:0];
                RG_SEG_R: seg_r <= wdata[SEG_W-1:0];
                RG_BANK:  bank  <= wdata[BANK_W-1:0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/mmio_regbank.sv
module mmio_regbank
    import mmio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [SW_W-1:0]      sw_in,
    output logic [LED_W-1:0]     led_out,
    output logic [SEG_W-1:0]     seg_left,
    output logic [SEG_W-1:0]     seg_right,
    output logic                 vga_sel,
    output logic                 vga_we,
    output logic [VGA_IDX_W-1:0] vga_idx,
    output logic [DATA_W-1:0]    vga_wdata,
    input  logic [DATA_W-1:0]    vga_rdata
);

    bus_dec_t             dec;
    logic [TIMER_W-1:0]   timer;
    logic [IND_N-1:0]     ind;
    logic [BANK_W-1:0]    bank;
    logic                 wr_en;
    logic                 unused_sw;

    mmio_decode u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    mmio_timer #(.W(TIMER_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .count (timer)
    );

    assign wr_en = bus_we && dec.page_hit;

    mmio_wregs u_wregs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .idx   (dec.idx),
        .wdata (bus_wdata),
        .ind   (ind),
        .seg_l (seg_left),
        .seg_r (seg_right),
        .bank  (bank)
    );

    for (genvar k = 0; k < IND_N; k++) begin : g_led
        assign led_out[LED_W-1-k] = ind[k];
    end
    assign led_out[BANK_W-1:0] = bank;

    assign vga_sel   = dec.vga_hit;
    assign vga_we    = bus_we && dec.vga_hit;
    assign vga_idx   = dec.vga_idx;
    assign vga_wdata = bus_wdata;

    always_comb begin
        bus_rdata = '0;
        if (dec.page_hit) begin
            case (dec.idx)
                RG_MODE:  bus_rdata[0]            = sw_in[SW_MODE_BIT];
                RG_CASE:  bus_rdata[SW_CASE_W-1:0] = sw_in[SW_CASE_HI:SW_CASE_LO];
                RG_OPA:   bus_rdata[SW_OP_W-1:0]   = sw_in[SW_OPA_HI:SW_OPA_LO];
                RG_OPB:   bus_rdata[SW_OP_W-1:0]   = sw_in[SW_OPB_HI:SW_OPB_LO];
                RG_TM_HI: bus_rdata = timer[TIMER_W-1:DATA_W];
                RG_TM_LO: bus_rdata = timer[DATA_W-1:0];
                RG_IND0:  bus_rdata[0] = ind[0];
                RG_IND1:  bus_rdata[0] = ind[1];
                RG_IND2:  bus_rdata[0] = ind[2];
                RG_IND3:  bus_rdata[0] = ind[3];
                RG_SEG_L: bus_rdata[SEG_W-1:0]  = seg_left;
                RG_SEG_R: bus_rdata[SEG_W-1:0]  = seg_right;
                RG_BANK:  bus_rdata[BANK_W-1:0] = bank;
                default:  bus_rdata = '0;
            endcase
        end else if (dec.vga_hit) begin
            bus_rdata = vga_rdata;
        end
    end

    assign unused_sw = ^sw_in[SW_CASE_LO-1:SW_OPA_HI+1];

endmodule

// File: rtl/mmio_regbank_chk.sv
module mmio_regbank_chk
    import mmio_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [LED_W-1:0]     led_out,
    input logic [SEG_W-1:0]     seg_left,
    input logic [SEG_W-1:0]     seg_right,
    input logic                 vga_sel,
    input logic                 vga_we,
    input logic [DATA_W-1:0]    vga_rdata
);

    localparam logic [ADDR_W-1:0] A_TMLO = PAGE_BASE + 32'h1c;
    localparam logic [ADDR_W-1:0] A_BANK = PAGE_BASE + 32'h38;
    localparam logic [ADDR_W-1:0] A_KP   = PAGE_BASE + 32'h14;
    localparam logic [ADDR_W-1:0] A_BUZ  = PAGE_BASE + 32'h3c;

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (led_out == '0 && seg_left == '0 && seg_right == '0));

    a_r3_timer_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && bus_addr == A_TMLO && $past(bus_addr) == A_TMLO)
        |-> bus_rdata == $past(bus_rdata) + 32'd1);

    a_r6_bank_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_we) && $past(bus_addr) == A_BANK)
        |-> led_out[BANK_W-1:0] == $past(bus_wdata[BANK_W-1:0]));

    a_r10_hold_without_store: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_we))
        |-> ($stable(led_out) && $stable(seg_left) && $stable(seg_right)));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == PAGE_BASE || bus_addr == A_KP || bus_addr == A_BUZ) |-> bus_rdata == '0);

    a_r8_window_read: assert property (@(posedge clk) disable iff (rst)
        vga_sel |-> bus_rdata == vga_rdata);

    a_r8_window_store: assert property (@(posedge clk) disable iff (rst)
        vga_we |-> (vga_sel && bus_we));

    a_r9_below_page: assert property (@(posedge clk) disable iff (rst)
        (bus_addr < PAGE_BASE) |-> (!vga_sel && bus_rdata == '0));

endmodule

bind mmio_regbank mmio_regbank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .led_out   (led_out),
    .seg_left  (seg_left),
    .seg_right (seg_right),
    .vga_sel   (vga_sel),
    .vga_we    (vga_we),
    .vga_rdata (vga_rdata)
);

// File: tb/tb_mmio_regbank.sv
module tb_mmio_regbank;
    import mmio_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic                 bus_we = 1'b0;
    logic [DATA_W-1:0]    bus_wdata = '0;
    logic [DATA_W-1:0]    bus_rdata;
    logic [SW_W-1:0]      sw_in = '0;
    logic [LED_W-1:0]     led_out;
    logic [SEG_W-1:0]     seg_left;
    logic [SEG_W-1:0]     seg_right;
    logic                 vga_sel;
    logic                 vga_we;
    logic [VGA_IDX_W-1:0] vga_idx;
    logic [DATA_W-1:0]    vga_wdata;
    logic [DATA_W-1:0]    vga_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    mmio_regbank dut (
        .clk (clk), .rst (rst),
        .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .sw_in (sw_in), .led_out (led_out), .seg_left (seg_left), .seg_right (seg_right),
        .vga_sel (vga_sel), .vga_we (vga_we), .vga_idx (vga_idx),
        .vga_wdata (vga_wdata), .vga_rdata (vga_rdata)
    );

    // offset[71:64], store data[63:32], expected readback[31:0]
    localparam int NV = 13;
    localparam logic [71:0] VEC [NV] = '{
        {8'h20, 32'hFFFF_FFFE, 32'h0000_0000},
        {8'h20, 32'h0000_0001, 32'h0000_0001},
        {8'h24, 32'h0000_0003, 32'h0000_0001},
        {8'h28, 32'h0000_0001, 32'h0000_0001},
        {8'h28, 32'h8000_0000, 32'h0000_0000},
        {8'h2c, 32'hFFFF_FFFF, 32'h0000_0001},
        {8'h30, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {8'h34, 32'h1234_5678, 32'h1234_5678},
        {8'h38, 32'hABCD_1234, 32'h0000_1234},
        {8'h00, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h14, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h3c, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h04, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    function automatic string tag_of(input logic [7:0] off);
        if (off >= 8'h20 && off <= 8'h2c) return "R4 indicator";
        if (off == 8'h30 || off == 8'h34) return "R5 seven-segment";
        if (off == 8'h38) return "R6 bank";
        return "R7 reserved/read-only";
    endfunction

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] v;
        logic [DATA_W-1:0] t0;

        // R1: reset state
        repeat (3) @(posedge clk);
        rd(PAGE_BASE + 32'h1c, v); check("R1 timer low in reset", v, 0);
        rd(PAGE_BASE + 32'h18, v); check("R1 timer high in reset", v, 0);
        check("R1 leds in reset", led_out, 0);
        check("R1 seg_left in reset", seg_left, 0);
        check("R1 seg_right in reset", seg_right, 0);
        rd(PAGE_BASE + 32'h38, v); check("R1 bank readback in reset", v, 0);
        @(negedge clk); rst = 1'b0;

        // R3: counter steps
        rd(PAGE_BASE + 32'h1c, t0);
        rd(PAGE_BASE + 32'h1c, v); check("R3 timer +1", v, t0 + 1);
        repeat (4) @(negedge clk);
        rd(PAGE_BASE + 32'h1c, v); check("R3 timer +6", v, t0 + 6);
        rd(PAGE_BASE + 32'h18, v); check("R3 timer high word", v, 0);

        // R4 R5 R6 R7: store/readback vectors
        for (int i = 0; i < NV; i++) begin
            wr(PAGE_BASE + 32'(VEC[i][71:64]), VEC[i][63:32]);
            rd(PAGE_BASE + 32'(VEC[i][71:64]), v);
            check(tag_of(VEC[i][71:64]), v, VEC[i][31:0]);
        end
        check("R4 R6 R7 led_out after table", led_out, 20'hD1234);
        check("R5 R7 seg_left after table", seg_left, 32'hDEAD_BEEF);
        check("R5 R7 seg_right after table", seg_right, 32'h1234_5678);
        wr(PAGE_BASE + 32'h1c, 32'hFFFF_FFFF);
        wr(PAGE_BASE + 32'h10, 32'hFFFF_FFFF);
        check("R7 read-only store ignored", led_out, 20'hD1234);

        // R2: switch slices, two patterns
        sw_in = 24'hAF963C;
        rd(PAGE_BASE + 32'h04, v); check("R2 mode bit", v, 1);
        rd(PAGE_BASE + 32'h08, v); check("R2 case field", v, 2);
        rd(PAGE_BASE + 32'h0c, v); check("R2 operand A", v, 32'h96);
        rd(PAGE_BASE + 32'h10, v); check("R2 operand B", v, 32'h3C);
        sw_in = 24'h7000FF;
        rd(PAGE_BASE + 32'h04, v); check("R2 mode bit low", v, 0);
        rd(PAGE_BASE + 32'h08, v); check("R2 case field max", v, 7);
        rd(PAGE_BASE + 32'h0c, v); check("R2 operand A zero", v, 0);
        rd(PAGE_BASE + 32'h10, v); check("R2 operand B no sign ext", v, 32'hFF);

        // R10: store and readback in the same cycle
        @(negedge clk);
        bus_addr = PAGE_BASE + 32'h38; bus_wdata = 32'h0000_BEEF; bus_we = 1'b1;
        #1;
        check("R10 old value during store", bus_rdata, 32'h1234);
        @(posedge clk); #1; bus_we = 1'b0;
        check("R10 new value after edge", bus_rdata, 32'hBEEF);
        @(negedge clk); bus_wdata = 32'h0000_5555;
        @(posedge clk); #1;
        check("R10 no store without strobe", bus_rdata, 32'hBEEF);

        // R8: text-buffer window
        @(negedge clk);
        vga_rdata = 32'h55AA_1234;
        bus_addr = 32'hffff_0100; bus_wdata = 32'hCAFE_0001; bus_we = 1'b1;
        #1;
        check("R8 first word select", {vga_sel, vga_we}, 2'b11);
        check("R8 first word index", vga_idx, 0);
        check("R8 data forward", vga_wdata, 32'hCAFE_0001);
        check("R8 read from buffer", bus_rdata, 32'h55AA_1234);
        bus_addr = 32'hffff_0a5c; #1;
        check("R8 last word select", vga_sel, 1);
        check("R8 last word index", vga_idx, 599);

        // R9: edges outside both windows
        bus_addr = 32'hffff_0a60; #1;
        check("R9 past window end", {vga_sel, vga_we}, 2'b00);
        check("R9 past window end read", bus_rdata, 0);
        bus_addr = 32'hffff_00fc; #1;
        check("R9 gap below window", {vga_sel, bus_rdata}, 33'h0);
        bus_addr = 32'hffff_0040; #1;
        check("R9 just above page", {vga_sel, bus_rdata}, 33'h0);
        @(posedge clk); #1; bus_we = 1'b0;
        wr(32'h0000_0038, 32'h0000_FFFF);
        check("R9 unmapped store ignored", led_out, 20'hDBEEF);
        rd(PAGE_BASE + 32'h38, v); check("R9 bank readback intact", v, 32'hBEEF);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule